// File: doc/BRIEF.md
# Stack and Call/Return Sequencer

This block owns the stack pointer and the instruction pointer of a small processor datapath. It carries out the multi-cycle memory work behind six stack operations: push of a register, pop into a register, push and pop of the flags word, subroutine call and subroutine return. Memory is 32-bit and byte-addressed. The block reaches it through a single word port. A request is held until the memory answers with a ready strobe, and read data is taken in the ready cycle.

A caller presents one operation with its operands and pulses start. The block latches everything on acceptance and reports busy while it works. When it finishes it gives a one-cycle done pulse; at that point the pointers and any popped value are already visible. A call takes its target in one of three ways: from the immediate, from the register operand, or from the memory word whose address is the register operand. In the third case the target is read before the return address is pushed.

Top module: `stack_seq`

## Requirements
- R1: While reset is asserted and after it is released, sp_o equals SP_RST, ip_o equals IP_RST, and busy_o, done_o, mem_req_o, reg_we_o and flags_we_o are 0.
- R2: Register push (op_i=0) performs one write of reg_val_i to address sp-4. When it completes, sp_o becomes sp-4.
- R3: Register pop (op_i=1) performs one read at address sp. On done, load_data_o carries the word read and reg_we_o pulses high for the done cycle. sp_o becomes sp+4.
- R4: Flags push (op_i=2) writes flags_i to sp-4 and lowers sp by 4. Flags pop (op_i=3) reads at sp, pulses flags_we_o with the word on load_data_o, and raises sp by 4. Only one of reg_we_o and flags_we_o is ever high.
- R5: Call (op_i=4) with tgt_mode_i=0 uses imm_i as the target, and with tgt_mode_i=1 uses reg_val_i. It writes ret_addr_i to sp-4, then sp_o becomes sp-4 and ip_o becomes the target.
- R6: Call with tgt_mode_i[1]=1 first reads the word at address reg_val_i. sp_o stays unchanged until that read has completed. The block then writes ret_addr_i to sp-4, and ip_o becomes the word read.
- R7: Return (op_i=5) reads at sp. ip_o becomes the word read and sp_o becomes sp+4. ip_o changes only in the cycle after a completed memory handshake.
- R8: All operands are latched when start_i is accepted in an idle cycle. busy_o is high from the next cycle until completion. done_o pulses for exactly one cycle, one cycle after the final handshake, and busy_o is low while done_o is high. start_i is ignored while busy_o is high.
- R9: A memory request holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o stable until mem_ready_i is seen.
- R10: Stack pointer arithmetic wraps modulo 2^32: a push from 0 leaves 0xFFFFFFFC, and a pop from 0xFFFFFFFC leaves 0. sp_o only ever changes by exactly 4.
- R11: Undefined operation codes 6 and 7 give done one cycle after acceptance. They make no memory request and leave sp_o and ip_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 3 | Operation code (0 push, 1 pop, 2 flags push, 3 flags pop, 4 call, 5 return) |
| tgt_mode_i | input | 2 | Call target source: 0 immediate, 1 register, 2 or 3 memory at register |
| imm_i | input | 32 | Immediate call target |
| reg_val_i | input | 32 | Register operand: push source, call target or indirect address |
| flags_i | input | 32 | Current flags word for flags push |
| ret_addr_i | input | 32 | Address of the instruction after the call |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| load_data_o | output | 32 | Word popped by the last pop or flags pop |
| reg_we_o | output | 1 | Write load_data_o into the destination register |
| flags_we_o | output | 1 | Write load_data_o into the flags register |
| sp_o | output | 32 | Stack pointer |
| ip_o | output | 32 | Instruction pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |

## Verification
The hardest case to reach is a memory-indirect call under memory stalls, with start pulsed again while the block is busy. Here the target read and the return-address push must come out in the right order, with the right addresses, and with the stack pointer frozen across the read. A second hard case is a target word whose address overlaps the slot about to be pushed. The bench covers both with a responder that inserts 0 to 3 random wait cycles on every request and logs each handshake. It also runs directed indirect calls with an extra start pulse during busy, and random calls whose indirect address is drawn near the stack. Three directed pushes starting from a stack pointer of 8 drive the pointer across zero and back.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_PUSHF = 3'd2,
    OP_POPF  = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    TGT_IMM  = 2'd0,
    TGT_REG  = 2'd1,
    TGT_MEM  = 2'd2,
    TGT_MEMX = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } state_e;
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  op_e    op_i,
  input  tgt_e   mode_i,
  input  logic   mem_ready_i,
  output logic   accept_o,
  output state_e state_o,
  output op_e    op_q_o,
  output logic   done_o
);
  state_e state_q, state_d;
  op_e    op_q;
  logic   done_q;
  logic   finish;
  logic   indirect;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign indirect = (mode_i == TGT_MEM) || (mode_i == TGT_MEMX);

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          unique case (op_i)
            OP_PUSH, OP_PUSHF:        state_d = ST_WRITE;
            OP_POP, OP_POPF, OP_RET:  state_d = ST_READ;
            OP_CALL:                  state_d = indirect ? ST_FETCH : ST_WRITE;
            default:                  finish  = 1'b1;  // undefined code: complete at once
          endcase
        end
      end
      ST_FETCH: if (mem_ready_i) state_d = ST_WRITE;
      ST_WRITE, ST_READ: begin
        if (mem_ready_i) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PUSH;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept_o) op_q <= op_i;
    end
  end

  assign state_o = state_q;
  assign op_q_o  = op_q;
  assign done_o  = done_q;
endmodule

// File: rtl/stack_seq_regs.sv
module stack_seq_regs
  import stack_seq_pkg::*;
#(
  parameter int unsigned          DW     = 32,
  parameter logic [DW-1:0]        SP_RST = '0,
  parameter logic [DW-1:0]        IP_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  op_e           op_i,
  input  tgt_e          mode_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] ret_addr_i,
  input  state_e        state_i,
  input  op_e           op_q_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] load_o,
  output logic          reg_we_o,
  output logic          flags_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  logic [DW-1:0] sp_q, ip_q, load_q, wdata_q, tgt_q;
  logic          reg_we_q, flags_we_q;
  logic [DW-1:0] sp_dec, sp_inc;

  assign sp_dec = sp_q - STEP;
  assign sp_inc = sp_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q       <= SP_RST;
      ip_q       <= IP_RST;
      load_q     <= '0;
      wdata_q    <= '0;
      tgt_q      <= '0;
      reg_we_q   <= 1'b0;
      flags_we_q <= 1'b0;
    end else begin
      reg_we_q   <= 1'b0;
      flags_we_q <= 1'b0;
      if (accept_i) begin
        unique case (op_i)
          OP_PUSHF: wdata_q <= flags_i;
          OP_CALL:  wdata_q <= ret_addr_i;
          default:  wdata_q <= reg_val_i;
        endcase
        // tgt_q holds the target, or the indirect address until the fetch returns
        tgt_q <= (mode_i == TGT_IMM) ? imm_i : reg_val_i;
      end
      if (mem_ready_i) begin
        unique case (state_i)
          ST_FETCH: tgt_q <= mem_rdata_i;
          ST_WRITE: begin
            sp_q <= sp_dec;
            if (op_q_i == OP_CALL) ip_q <= tgt_q;
          end
          ST_READ: begin
            sp_q <= sp_inc;
            if (op_q_i == OP_RET) begin
              ip_q <= mem_rdata_i;
            end else begin
              load_q     <= mem_rdata_i;
              reg_we_q   <= (op_q_i == OP_POP);
              flags_we_q <= (op_q_i == OP_POPF);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_i)
      ST_FETCH: mem_addr_o = tgt_q;
      ST_WRITE: mem_addr_o = sp_dec;
      default:  mem_addr_o = sp_q;
    endcase
  end

  assign mem_wdata_o = wdata_q;
  assign sp_o        = sp_q;
  assign ip_o        = ip_q;
  assign load_o      = load_q;
  assign reg_we_o    = reg_we_q;
  assign flags_we_o  = flags_we_q;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int unsigned   DW     = 32,
  parameter logic [DW-1:0] SP_RST = DW'(32'h0000_1000),
  parameter logic [DW-1:0] IP_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    tgt_mode_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] ret_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] load_data_o,
  output logic          reg_we_o,
  output logic          flags_we_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] ip_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i
);
  op_e    op_in, op_q;
  tgt_e   mode_in;
  state_e state;
  logic   accept;

  assign op_in   = op_e'(op_i);
  assign mode_in = tgt_e'(tgt_mode_i);

  stack_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (op_in),
    .mode_i      (mode_in),
    .mem_ready_i (mem_ready_i),
    .accept_o    (accept),
    .state_o     (state),
    .op_q_o      (op_q),
    .done_o      (done_o)
  );

  stack_seq_regs #(
    .DW     (DW),
    .SP_RST (SP_RST),
    .IP_RST (IP_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .op_i        (op_in),
    .mode_i      (mode_in),
    .imm_i       (imm_i),
    .reg_val_i   (reg_val_i),
    .flags_i     (flags_i),
    .ret_addr_i  (ret_addr_i),
    .state_i     (state),
    .op_q_i      (op_q),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .sp_o        (sp_o),
    .ip_o        (ip_o),
    .load_o      (load_data_o),
    .reg_we_o    (reg_we_o),
    .flags_we_o  (flags_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign busy_o    = (state != ST_IDLE);
  assign mem_req_o = busy_o;
  assign mem_we_o  = (state == ST_WRITE);
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          reg_we_o,
  input logic          flags_we_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] ip_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r6_sp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mem_ready_i) |=> $stable(sp_o));

  a_r7_ip_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mem_ready_i) |=> $stable(ip_o));

  a_r10_sp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> (sp_o == $past(sp_o) + STEP) || (sp_o == $past(sp_o) - STEP));

  a_r4_we_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, flags_we_o}));

  a_r3_we_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || flags_we_o) |-> done_o);
endmodule

bind stack_seq stack_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .reg_we_o    (reg_we_o),
  .flags_we_o  (flags_we_o),
  .sp_o        (sp_o),
  .ip_o        (ip_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  localparam logic [31:0] SP0 = 32'h0000_0008;
  localparam logic [31:0] IP0 = 32'h0000_0100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  tgt_mode_i = '0;
  logic [31:0] imm_i = '0, reg_val_i = '0, flags_i = '0, ret_addr_i = '0;
  logic        busy_o, done_o, reg_we_o, flags_we_o, mem_req_o, mem_we_o;
  logic [31:0] load_data_o, sp_o, ip_o, mem_addr_o, mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int acc_n = 0;
  int wait_left = 0;
  logic [31:0] acc_a [4];
  logic        acc_w [4];
  logic [31:0] acc_d [4];
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] m_sp = SP0, m_ip = IP0;

  always #2 clk_i = ~clk_i;

  stack_seq #(.DW(32), .SP_RST(SP0), .IP_RST(IP0)) u_stack_seq (
    .clk_i, .rst_ni, .start_i, .op_i, .tgt_mode_i, .imm_i, .reg_val_i, .flags_i,
    .ret_addr_i, .busy_o, .done_o, .load_data_o, .reg_we_o, .flags_we_o, .sp_o,
    .ip_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i,
    .mem_rdata_i
  );

  function automatic logic [31:0] rd_val(input logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with random wait states and an access log
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_ready_i = 1'b0;
    end else if (mem_ready_i) begin
      mem_ready_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_left == 0) begin
        mem_ready_i = 1'b1;
        wait_left = $urandom_range(0, 3);
        if (acc_n < 4) begin
          acc_a[acc_n] = mem_addr_o;
          acc_w[acc_n] = mem_we_o;
          acc_d[acc_n] = mem_wdata_o;
        end
        acc_n++;
        if (mem_we_o) shadow[mem_addr_o] = mem_wdata_o;
        else mem_rdata_i = rd_val(mem_addr_o);
      end else begin
        wait_left--;
      end
    end
    if (done_o) done_cnt++;
  end

  task automatic run_op(input logic [2:0] op, input logic [1:0] md,
                        input logic [31:0] imm, rv, fl, ra, input bit poke);
    int          e_n = 0;
    logic [31:0] ea [2], ed [2];
    logic        ew [2];
    logic [31:0] e_sp = m_sp, e_ip = m_ip, e_ld = '0, tgt;
    bit          e_rwe = 0, e_fwe = 0;
    string       tag;
    int          guard;
    ea[0] = '0; ea[1] = '0; ed[0] = '0; ed[1] = '0; ew[0] = 0; ew[1] = 0;
    case (op)
      3'd0, 3'd2: begin
        tag = (op == 3'd0) ? "R2" : "R4";
        e_n = 1; ea[0] = m_sp - 4; ew[0] = 1; ed[0] = (op == 3'd0) ? rv : fl;
        e_sp = m_sp - 4;
      end
      3'd1, 3'd3: begin
        tag = (op == 3'd1) ? "R3" : "R4";
        e_n = 1; ea[0] = m_sp; ew[0] = 0; e_ld = rd_val(m_sp);
        e_sp = m_sp + 4; e_rwe = (op == 3'd1); e_fwe = (op == 3'd3);
      end
      3'd4: begin
        if (md[1]) begin
          tag = "R6";
          e_n = 2; ea[0] = rv; ew[0] = 0; tgt = rd_val(rv);
          ea[1] = m_sp - 4; ew[1] = 1; ed[1] = ra;
        end else begin
          tag = "R5";
          e_n = 1; ea[0] = m_sp - 4; ew[0] = 1; ed[0] = ra;
          tgt = (md == 2'd0) ? imm : rv;
        end
        e_ip = tgt; e_sp = m_sp - 4;
      end
      3'd5: begin
        tag = "R7";
        e_n = 1; ea[0] = m_sp; ew[0] = 0;
        e_ip = rd_val(m_sp); e_sp = m_sp + 4;
      end
      default: tag = "R11";
    endcase

    @(negedge clk_i);
    acc_n = 0; done_cnt = 0;
    op_i = op; tgt_mode_i = md; imm_i = imm; reg_val_i = rv; flags_i = fl; ret_addr_i = ra;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // operands must have been latched: scramble them now
    imm_i = $urandom; reg_val_i = $urandom; flags_i = $urandom; ret_addr_i = $urandom;
    if (op <= 3'd5) begin
      chk(busy_o == 1'b1, "R8 busy after accept", 32'(busy_o), 32'd1);
      if (poke) begin
        op_i = 3'd0; start_i = 1'b1;  // R8: must be ignored while busy
        @(negedge clk_i);
        start_i = 1'b0;
      end
    end
    guard = 0;
    while (!done_o && guard < 64) begin
      @(negedge clk_i);
      guard++;
    end
    chk(done_o == 1'b1, {tag, " done seen"}, 32'(done_o), 32'd1);
    chk(busy_o == 1'b0, "R8 idle at done", 32'(busy_o), 32'd0);
    chk(sp_o == e_sp, {tag, " sp"}, sp_o, e_sp);
    chk(ip_o == e_ip, {tag, " ip"}, ip_o, e_ip);
    chk(acc_n == e_n, {tag, " access count"}, 32'(acc_n), 32'(e_n));
    for (int k = 0; k < e_n && k < acc_n; k++) begin
      chk(acc_a[k] == ea[k], {tag, " access address"}, acc_a[k], ea[k]);
      chk(acc_w[k] == ew[k], {tag, " access direction"}, 32'(acc_w[k]), 32'(ew[k]));
      if (ew[k]) chk(acc_d[k] == ed[k], {tag, " write data"}, acc_d[k], ed[k]);
    end
    chk(reg_we_o == e_rwe, "R3 reg_we", 32'(reg_we_o), 32'(e_rwe));
    chk(flags_we_o == e_fwe, "R4 flags_we", 32'(flags_we_o), 32'(e_fwe));
    if (e_rwe || e_fwe) chk(load_data_o == e_ld, {tag, " load data"}, load_data_o, e_ld);
    m_sp = e_sp; m_ip = e_ip;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done single cycle", 32'(done_o), 32'd0);
    chk(done_cnt == 1, "R8 one done per op", 32'(done_cnt), 32'd1);
    chk(mem_req_o == 1'b0, "R8 no extra request", 32'(mem_req_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240901));
    repeat (3) @(negedge clk_i);
    // R1 reset state, held in reset
    chk(sp_o == SP0, "R1 sp in reset", sp_o, SP0);
    chk(ip_o == IP0, "R1 ip in reset", ip_o, IP0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sp_o == SP0, "R1 sp", sp_o, SP0);
    chk(ip_o == IP0, "R1 ip", ip_o, IP0);
    chk({busy_o, done_o, mem_req_o, reg_we_o, flags_we_o} == 5'b0, "R1 controls",
        32'({busy_o, done_o, mem_req_o, reg_we_o, flags_we_o}), 32'd0);

    // R10 wrap downward across zero and back
    run_op(3'd0, 2'd0, '0, 32'hAAAA_0001, '0, '0, 0);
    run_op(3'd2, 2'd0, '0, '0, 32'h0000_08C5, '0, 0);
    run_op(3'd0, 2'd0, '0, 32'hBEEF_0003, '0, '0, 1);
    chk(sp_o == 32'hFFFF_FFFC, "R10 wrap down", sp_o, 32'hFFFF_FFFC);
    run_op(3'd1, 2'd0, '0, '0, '0, '0, 0);
    chk(sp_o == 32'h0, "R10 wrap up", sp_o, 32'h0);
    chk(load_data_o == 32'hBEEF_0003, "R3 popped value", load_data_o, 32'hBEEF_0003);
    run_op(3'd3, 2'd0, '0, '0, '0, '0, 0);
    chk(load_data_o == 32'h0000_08C5, "R4 flags popped", load_data_o, 32'h0000_08C5);
    // R5 immediate and register calls, R7 returns
    run_op(3'd4, 2'd0, 32'h0000_4000, 32'h1, '0, 32'h0000_0104, 1);
    run_op(3'd5, 2'd0, '0, '0, '0, '0, 0);
    chk(ip_o == 32'h0000_0104, "R7 return address", ip_o, 32'h0000_0104);
    run_op(3'd4, 2'd1, 32'h1, 32'h0000_5000, '0, 32'h0000_0108, 0);
    run_op(3'd5, 2'd0, '0, '0, '0, '0, 1);
    // R6 indirect call: target table word then push
    shadow[32'h0000_2000] = 32'h0000_6000;
    run_op(3'd4, 2'd2, '0, 32'h0000_2000, '0, 32'h0000_010C, 1);
    chk(ip_o == 32'h0000_6000, "R6 indirect target", ip_o, 32'h0000_6000);
    run_op(3'd4, 2'd3, '0, m_sp - 4, '0, 32'h0000_0110, 0);
    run_op(3'd5, 2'd0, '0, '0, '0, '0, 0);
    // R11 undefined codes
    run_op(3'd6, 2'd0, '0, '0, '0, '0, 0);
    run_op(3'd7, 2'd2, '0, '0, '0, '0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  op = 3'($urandom_range(0, 7));
      logic [1:0]  md = 2'($urandom_range(0, 3));
      logic [31:0] rv = $urandom;
      if (op == 3'd4 && md[1] && $urandom_range(0, 1) == 1) rv = m_sp + 32'($urandom_range(0, 3) * 4) - 8;
      run_op(op, md, $urandom, rv, $urandom, $urandom, $urandom_range(0, 1) == 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule